// File: doc/BRIEF.md
# Priority Interrupt Controller with Priority LIFO

The block takes a set of peripheral interrupt sources. Each source carries its own 4-bit priority, and the block reduces them to a single interrupt request for the processor. When no request is outstanding, the block picks the best pending source whose priority is strictly above the running priority. It raises `irq_o` and freezes that source's index as the vector number. The frozen vector and its priority then hold until the processor acknowledges, even if a more urgent source shows up in the meantime.

A hardware acknowledge does three things in one cycle. It drops the request, saves the running priority on a 15-entry LIFO, and raises the running priority to that of the acknowledged source. The handler address is built combinationally from the frozen vector in one of two fixed bit layouts, and a mode input selects which one. An end-of-interrupt strobe pops the saved priority back. A pop with nothing saved, or a push with no room, sets a sticky error flag and leaves the stack as it was. Five of the inputs are typically driven by external-pin flag logic, but every source input is treated the same way.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0, `cur_prio_o` is 0, `lifo_err_o` is 0, and the priority LIFO is empty.
- R2: A source is eligible when its `src_req_i` bit is 1 and its priority field `src_prio_i[4*i+3:4*i]` is strictly greater than `cur_prio_o`, so priority 0 never interrupts. Among eligible sources the highest priority wins, and ties go to the lowest index. While `irq_o` is 0 and an eligible source exists, `irq_o` rises on the next clock edge and `vec_o` shows the winner's index.
- R3: A clock edge with `ack_i` = 1 while `irq_o` = 1 drives `irq_o` to 0.
- R4: While `irq_o` is 1 and `ack_i` is 0, `irq_o` stays 1 and `vec_o` does not change, even when a higher-priority source becomes pending.
- R5: On an acknowledged edge, the old `cur_prio_o` is pushed onto the LIFO. In the same edge, `cur_prio_o` becomes the priority that the vector's source had when the vector was latched.
- R6: The cycle after an acknowledge, eligibility is evaluated again against the new `cur_prio_o`. `irq_o` rises again, with a freshly latched vector, one edge later only if an eligible source remains.
- R7: A clock edge with `eoi_i` = 1 and no acknowledge pops the top LIFO entry into `cur_prio_o`.
- R8: An `eoi_i` with an empty LIFO, or an acknowledge with a full LIFO (15 entries), sets `lifo_err_o`. The LIFO contents stay unchanged, an empty pop leaves `cur_prio_o` unchanged, and `lifo_err_o` stays 1 until reset.
- R9: With `fmt_sel_i` = 0, `handler_addr_o` is laid out as follows: `base_a_i` in [31:12], 1 in [11], `vec_o` in [10:2], and 00 in [1:0].
- R10: With `fmt_sel_i` = 1, `handler_addr_o` is laid out as follows: `base_b_i` in [31:16], 000 in [15:13], `vec_o` in [12:4], and 0000 in [3:0].
- R11: `ack_i` while `irq_o` is 0 has no effect. In that cycle `cur_prio_o` and the LIFO are untouched, and `eoi_i` is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_req_i | input | N_SRC | Pending flag per source |
| src_prio_i | input | 4*N_SRC | Packed 4-bit priority per source |
| ack_i | input | 1 | Hardware acknowledge from the processor |
| eoi_i | input | 1 | End-of-interrupt strobe, pops saved priority |
| fmt_sel_i | input | 1 | Handler address layout: 0 = format A, 1 = format B |
| base_a_i | input | 20 | Vector base for format A |
| base_b_i | input | 16 | Prefix for format B |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 9 | Latched vector number (source index) |
| cur_prio_o | output | 4 | Running priority |
| handler_addr_o | output | 32 | Handler address |
| lifo_err_o | output | 1 | Sticky LIFO overflow/underflow flag |

## Verification
The assertions about the request and vector take only the reset for granted. They hold for any pattern on the source and priority inputs, including sources that change or drop while a vector is frozen. The priority-rise check assumes that the running priority can only fall between latch and acknowledge, and that only an end-of-interrupt strobe lowers it. The stimulus obeys this by keeping `ack_i` and `eoi_i` out of the same cycle, and by pulsing `ack_i` mostly while a request is up, with a few stray pulses to cover the ignored case.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIO_W   = 4;
  localparam int VEC_W    = 9;
  localparam int ADDR_W   = 32;
  localparam int BASE_A_W = 20;
  localparam int BASE_B_W = 16;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic {
    FMT_A = 1'b0,
    FMT_B = 1'b1
  } addr_fmt_e;
endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  prio_t                   cur_i,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        idx_o,
  output prio_t                   prio_o
);
  // strict > against running best keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = cur_i;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_lifo.sv
module prio_irq_lifo #(
  parameter int DEPTH = 15,
  parameter int W     = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] wr_idx;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[wr_idx] <= din_i;
      cnt_q         <= cnt_q + CNT_W'(1);
    end else if (pop_i && !push_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/prio_irq_addr.sv
module prio_irq_addr
  import prio_irq_pkg::*;
(
  input  addr_fmt_e              fmt_i,
  input  logic [BASE_A_W-1:0]    base_a_i,
  input  logic [BASE_B_W-1:0]    base_b_i,
  input  vec_t                   vec_i,
  output addr_t                  addr_o
);
  always_comb begin
    unique case (fmt_i)
      FMT_A:   addr_o = {base_a_i, 1'b1, vec_i, 2'b00};
      FMT_B:   addr_o = {base_b_i, 3'b000, vec_i, 4'b0000};
      default: addr_o = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC      = 16,
  parameter int LIFO_DEPTH = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_req_i,
  input  logic [N_SRC*PRIO_W-1:0] src_prio_i,
  input  logic                    ack_i,
  input  logic                    eoi_i,
  input  logic                    fmt_sel_i,
  input  logic [BASE_A_W-1:0]     base_a_i,
  input  logic [BASE_B_W-1:0]     base_b_i,
  output logic                    irq_o,
  output logic [VEC_W-1:0]        vec_o,
  output logic [PRIO_W-1:0]       cur_prio_o,
  output logic [ADDR_W-1:0]       handler_addr_o,
  output logic                    lifo_err_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             irq_q, err_q;
  vec_t             vec_q;
  prio_t            vprio_q, cur_q;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  prio_t            win_prio;
  logic             ack_take, pop_req;
  prio_t            lifo_top;
  logic             lifo_full, lifo_empty;

  assign ack_take = irq_q & ack_i;
  assign pop_req  = eoi_i & ~ack_take;

  prio_irq_arb #(.N_SRC(N_SRC)) u_arb (
    .req_i   (src_req_i),
    .prio_i  (src_prio_i),
    .cur_i   (cur_q),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  prio_irq_lifo #(.DEPTH(LIFO_DEPTH), .W(PRIO_W)) u_lifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ack_take),
    .pop_i   (pop_req),
    .din_i   (cur_q),
    .top_o   (lifo_top),
    .full_o  (lifo_full),
    .empty_o (lifo_empty)
  );

  prio_irq_addr u_addr (
    .fmt_i    (addr_fmt_e'(fmt_sel_i)),
    .base_a_i (base_a_i),
    .base_b_i (base_b_i),
    .vec_i    (vec_q),
    .addr_o   (handler_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      vec_q   <= '0;
      vprio_q <= '0;
      cur_q   <= '0;
    end else if (ack_take) begin
      irq_q <= 1'b0;
      cur_q <= vprio_q;
    end else begin
      if (pop_req && !lifo_empty) cur_q <= lifo_top;
      // arbiter sees the pre-pop priority; vector frozen while irq_q
      if (!irq_q && win_valid) begin
        irq_q   <= 1'b1;
        vec_q   <= vec_t'(win_idx);
        vprio_q <= win_prio;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           err_q <= 1'b0;
    else if ((ack_take && lifo_full) || (pop_req && lifo_empty)) err_q <= 1'b1;
  end

  assign irq_o      = irq_q;
  assign vec_o      = vec_q;
  assign cur_prio_o = cur_q;
  assign lifo_err_o = err_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              fmt_sel_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [PRIO_W-1:0] cur_prio_o,
  input logic [ADDR_W-1:0] handler_addr_o,
  input logic              lifo_err_o
);
  // R3
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack_i |=> !irq_o);

  // R4
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o);

  // R4
  vec_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> $stable(vec_o));

  // R5
  prio_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack_i |=> cur_prio_o > $past(cur_prio_o));

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lifo_err_o |=> lifo_err_o);

  // R9
  fmt_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fmt_sel_i |-> handler_addr_o[11] && handler_addr_o[1:0] == 2'b00
                   && handler_addr_o[10:2] == vec_o);

  // R10
  fmt_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_sel_i |-> handler_addr_o[15:13] == 3'b000 && handler_addr_o[3:0] == 4'b0000
                  && handler_addr_o[12:4] == vec_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ack_i          (ack_i),
  .fmt_sel_i      (fmt_sel_i),
  .irq_o          (irq_o),
  .vec_o          (vec_o),
  .cur_prio_o     (cur_prio_o),
  .handler_addr_o (handler_addr_o),
  .lifo_err_o     (lifo_err_o)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int N = 16;
  localparam int D = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*4-1:0] prio_flat = '0;
  logic          ack = 1'b0, eoi = 1'b0, fmt = 1'b0;
  logic [19:0]   base_a = '0;
  logic [15:0]   base_b = '0;
  logic          irq, err;
  logic [8:0]    vec;
  logic [3:0]    cur;
  logic [31:0]   haddr;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .LIFO_DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(req), .src_prio_i(prio_flat),
    .ack_i(ack), .eoi_i(eoi), .fmt_sel_i(fmt), .base_a_i(base_a), .base_b_i(base_b),
    .irq_o(irq), .vec_o(vec), .cur_prio_o(cur), .handler_addr_o(haddr), .lifo_err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit m_irq, m_err;
  int m_vec, m_vprio, m_cur;
  int stk[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int best_src();
    int bp = m_cur;
    int bi = -1;
    for (int i = 0; i < N; i++) begin
      int p = int'(prio_flat[i*4 +: 4]);
      if (req[i] && p > bp) begin bp = p; bi = i; end
    end
    return bi;
  endfunction

  function automatic logic [31:0] exp_addr();
    return fmt ? {base_b, 3'b000, 9'(m_vec), 4'b0000}
               : {base_a, 1'b1, 9'(m_vec), 2'b00};
  endfunction

  task automatic model_reset();
    m_irq = 0; m_err = 0; m_vec = 0; m_vprio = 0; m_cur = 0;
    stk.delete();
  endtask

  // reference update for one edge, from inputs held across it
  task automatic model_edge();
    if (m_irq && ack) begin
      if (stk.size() < D) stk.push_back(m_cur); else m_err = 1;
      m_cur = m_vprio;
      m_irq = 0;
    end else begin
      int b = best_src();
      if (eoi) begin
        if (stk.size() > 0) m_cur = stk.pop_back(); else m_err = 1;
      end
      if (!m_irq && b >= 0) begin
        m_irq = 1; m_vec = b; m_vprio = int'(prio_flat[b*4 +: 4]);
      end
    end
  endtask

  task automatic compare_all();
    chk("R3/R6 irq_o", 32'(irq), 32'(m_irq));
    chk("R2/R4 vec_o", 32'(vec), 32'(m_vec));
    chk("R5/R7 cur_prio_o", 32'(cur), 32'(m_cur));
    chk("R8 lifo_err_o", 32'(err), 32'(m_err));
    chk(fmt ? "R10 handler_addr_o" : "R9 handler_addr_o", haddr, exp_addr());
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_prio(int i, int p);
    prio_flat[i*4 +: 4] = 4'(p);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    // R1 reset state
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 vec_o", 32'(vec), 0);
    chk("R1 cur_prio_o", 32'(cur), 0);
    chk("R1 lifo_err_o", 32'(err), 0);

    // R2 priority 0 never interrupts
    req[2] = 1'b1; set_prio(2, 0);
    cyc();
    chk("R2 prio0 ignored", 32'(irq), 0);

    // R2 highest priority, tie to lowest index
    req[3] = 1'b1; set_prio(3, 5);
    req[7] = 1'b1; set_prio(7, 5);
    req[1] = 1'b1; set_prio(1, 2);
    cyc();
    chk("R2 tie lowest index", 32'(vec), 3);
    chk("R2 irq raised", 32'(irq), 1);

    // R4 late higher-priority source does not disturb
    req[9] = 1'b1; set_prio(9, 12);
    cyc();
    chk("R4 irq held", 32'(irq), 1);
    chk("R4 vec frozen", 32'(vec), 3);

    // R3 / R5 acknowledge
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    chk("R3 irq dropped", 32'(irq), 0);
    chk("R5 cur raised", 32'(cur), 5);

    // R6 re-raise with fresh vector
    cyc();
    chk("R6 re-raised", 32'(irq), 1);
    chk("R6 new vector", 32'(vec), 9);

    // R9 / R10 address layouts
    base_a = 20'hABCDE; base_b = 16'h1234; fmt = 1'b0;
    #1;
    chk("R9 format A", haddr, {20'hABCDE, 1'b1, 9'd9, 2'b00});
    fmt = 1'b1;
    #1;
    chk("R10 format B", haddr, {16'h1234, 3'b000, 9'd9, 4'b0000});
    @(negedge clk);

    // ack vec 9, drop all sources
    ack = 1'b1; req = '0;
    cyc();
    ack = 1'b0;
    chk("R5 cur nested", 32'(cur), 12);

    // R11 stray ack is ignored
    ack = 1'b1;
    cyc();
    ack = 1'b0;
    chk("R11 ack ignored", 32'(cur), 12);

    // R7 pops
    eoi = 1'b1;
    cyc();
    chk("R7 pop 1", 32'(cur), 5);
    cyc();
    chk("R7 pop 2", 32'(cur), 0);
    // R8 underflow
    cyc();
    eoi = 1'b0;
    chk("R8 underflow err", 32'(err), 1);
    chk("R8 cur unchanged", 32'(cur), 0);
    cyc();
    chk("R8 err sticky", 32'(err), 1);

    // random phase
    do_reset();
    compare_all();
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        for (int i = 0; i < N; i++) begin
          req[i] = ($urandom_range(0, 5) == 0);
          set_prio(i, $urandom_range(0, 15));
        end
      end
      fmt    = 1'($urandom_range(0, 1));
      base_a = 20'($urandom);
      base_b = 16'($urandom);
      ack    = irq ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 19) == 0);
      eoi    = !ack && ($urandom_range(0, 6) == 0);
      cyc();
      if (n % 1000 == 999) begin
        ack = 1'b0; eoi = 1'b0;
        do_reset();
        compare_all();
      end
    end
    ack = 1'b0; eoi = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule